// File: doc/BRIEF.md
# Separate-Sync Video Capture

This block receives video carried with separate timing signals (a data-enable, a horizontal sync, a vertical sync and a field flag) next to a parallel pixel bus. It turns that stream into a framed pixel stream. Every input is qualified by a sample strobe, `vin_ok`. Only cycles with the strobe high carry a pixel time, so the capture clock may run at any multiple of the pixel rate. Each active pixel leaves the block with a one-clock valid pulse, a start-of-frame marker, an end-of-line marker and the field it belongs to.

Alongside the pixel path, the block measures each frame: the active width, the number of active lines, the total number of lines (counted by horizontal sync pulses) and a running frame count. It publishes those figures when a new frame begins. It also raises a flag once two frames in a row have the same active geometry.

Framing is controlled by a four-state machine:
- SEEK: reset state. The first qualified vertical sync rise moves it to VBLANK, or to ACTIVE if data-enable is already high on that sample.
- VBLANK: a sample with data-enable high moves it to ACTIVE and is marked start-of-frame.
- ACTIVE: a sample with data-enable low moves it to HBLANK.
- HBLANK: a sample with data-enable high moves it back to ACTIVE.

A qualified vertical sync rise takes precedence in every state except SEEK. It goes to VBLANK, or to ACTIVE with start-of-frame when data-enable is high on that sample.

Top module: `sepsync_capture`

## Requirements
- R1: Inputs are taken only on cycles where `vin_ok` is 1. The values on cycles with `vin_ok` at 0 have no effect, and `px_valid` is 0 on every clock that follows an unqualified cycle.
- R2: After framing has started, each qualified sample with `vin_de` at 1 yields exactly one output pixel carrying the same data. The pixel appears with `px_valid` high for one clock, after the edge that takes the next qualified sample. Pixels are delivered in input order.
- R3: Qualified samples taken before the first qualified rising edge of `vin_vs` produce no output pixel.
- R4: `px_sof` is 1 only with the first active pixel at or after a qualified rising edge of `vin_vs`. It is 0 for all other pixels.
- R5: `px_eol` is 1 with a pixel exactly when the next qualified sample has `vin_de` at 0.
- R6: `px_field` carries the value of `vin_fld` sampled at the qualified rising edge of `vin_vs` that opened the frame. Later changes of `vin_fld` within the frame do not alter it.
- R7: At each qualified rising edge of `vin_vs` after the first, `meas_width` takes the active-pixel count of the last line of the frame just ended, and `meas_height` takes its count of active lines. A line is counted when `vin_de` falls.
- R8: At the same edges, `meas_lines` takes the number of qualified rising edges of `vin_hs` in the frame just ended. A rise coinciding with the frame's opening `vin_vs` rise belongs to that frame.
- R9: `meas_fields` increases by exactly one at each qualified rising edge of `vin_vs` after the first, and at no other time.
- R10: `geom_stable` becomes 1 when a newly published width and height equal the previously published pair. It stays 1 while they keep matching and drops to 0 at the first publication that differs. The first publication after reset leaves it at 0.
- R11: A synchronous active-high `rst` clears all outputs, counters and the framing state.
- R12: Inserting any number of unqualified cycles between qualified samples leaves the pixel stream and the published measurements unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_ok | input | 1 | Sample qualifier; 1 marks a pixel time |
| vin_data | input | DATA_W | Pixel data |
| vin_de | input | 1 | Active picture enable |
| vin_hs | input | 1 | Horizontal sync, high during sync |
| vin_vs | input | 1 | Vertical sync, high during sync |
| vin_fld | input | 1 | Field flag, 1 for second interlaced field |
| px_data | output | DATA_W | Output pixel data |
| px_valid | output | 1 | One-clock pulse per output pixel |
| px_sof | output | 1 | First pixel of a frame |
| px_eol | output | 1 | Last pixel of a line |
| px_field | output | 1 | Field tag of the frame |
| meas_width | output | WIDTH_W | Active pixels per line of last frame |
| meas_height | output | HEIGHT_W | Active lines of last frame |
| meas_lines | output | HEIGHT_W | Horizontal sync pulses of last frame |
| meas_fields | output | FCNT_W | Count of published frames |
| geom_stable | output | 1 | Two consecutive frames match in geometry |

## Verification
The stream starts with an active line before any vertical sync. This shows that unframed samples are dropped. It is followed by frames at one, two and three unqualified cycles between samples, and every gap cycle toggles all inputs, so leakage from unqualified cycles is exposed. Frame sizes go from a single-pixel line (start-of-frame and end-of-line on the same pixel) to wider and taller frames. The sequence repeats and then changes the geometry so that the stability flag must rise, hold and drop. The field input is driven inverted outside the sync edge, which separates a tag latched at the frame edge from one that follows the live input. A trailing empty frame publishes the last geometry, and a final reset must clear every status output.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        ST_SEEK   = 2'd0,
        ST_VBLANK = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_HBLANK = 2'd3
    } cap_state_t;

    typedef struct packed {
        logic vs_rise;
        logic hs_rise;
        logic de_fall;
    } sync_edges_t;

endpackage

// File: rtl/ssc_sampler.sv
module ssc_sampler
    import ssc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ok,
    input  logic        de,
    input  logic        hs,
    input  logic        vs,
    output sync_edges_t ev
);

    logic prev_de;
    logic prev_hs;
    logic prev_vs;

    // Previous qualified levels; unqualified cycles leave them untouched.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_de <= 1'b0;
            prev_hs <= 1'b0;
            prev_vs <= 1'b0;
        end else if (ok) begin
            prev_de <= de;
            prev_hs <= hs;
            prev_vs <= vs;
        end
    end

    always_comb begin
        ev.vs_rise = ok & vs & ~prev_vs;
        ev.hs_rise = ok & hs & ~prev_hs;
        ev.de_fall = ok & ~de & prev_de;
    end

endmodule

// File: rtl/ssc_frame_fsm.sv
module ssc_frame_fsm
    import ssc_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ok,
    input  logic              de,
    input  logic              fld,
    input  logic [DATA_W-1:0] data,
    input  logic              vs_rise,
    output logic              framing,
    output logic [DATA_W-1:0] px_data,
    output logic              px_valid,
    output logic              px_sof,
    output logic              px_eol,
    output logic              px_field
);

    cap_state_t state;
    cap_state_t nxt;

    logic              hold_v;
    logic [DATA_W-1:0] hold_d;
    logic              hold_sof;
    logic              hold_fld;
    logic              frame_fld;

    logic take_now;
    logic sof_now;
    logic fld_now;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_SEEK;
        else     state <= nxt;
    end

    // Next state: a qualified vertical sync rise wins in every state
    always_comb begin
        nxt = state;
        if (ok) begin
            if (vs_rise) begin
                nxt = de ? ST_ACTIVE : ST_VBLANK;
            end else begin
                unique case (state)
                    ST_SEEK:   nxt = ST_SEEK;
                    ST_VBLANK: nxt = de ? ST_ACTIVE : ST_VBLANK;
                    ST_ACTIVE: nxt = de ? ST_ACTIVE : ST_HBLANK;
                    ST_HBLANK: nxt = de ? ST_ACTIVE : ST_HBLANK;
                endcase
            end
        end
    end

    always_comb begin
        framing  = (state != ST_SEEK);
        take_now = ok & de & (vs_rise | (state != ST_SEEK));
        sof_now  = vs_rise | (state == ST_VBLANK);
        fld_now  = vs_rise ? fld : frame_fld;
    end

    // Outputs: one-sample hold stage so line end is known when a pixel leaves
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v    <= 1'b0;
            hold_d    <= '0;
            hold_sof  <= 1'b0;
            hold_fld  <= 1'b0;
            frame_fld <= 1'b0;
            px_data   <= '0;
            px_valid  <= 1'b0;
            px_sof    <= 1'b0;
            px_eol    <= 1'b0;
            px_field  <= 1'b0;
        end else if (ok) begin
            if (vs_rise) frame_fld <= fld;
            px_valid <= hold_v;
            px_data  <= hold_d;
            px_sof   <= hold_v & hold_sof;
            px_eol   <= hold_v & ~de;
            px_field <= hold_fld;
            hold_v   <= take_now;
            if (take_now) begin
                hold_d   <= data;
                hold_sof <= sof_now;
                hold_fld <= fld_now;
            end
        end else begin
            px_valid <= 1'b0;
            px_sof   <= 1'b0;
            px_eol   <= 1'b0;
        end
    end

    AST_NO_EMIT_UNQUALIFIED: assert property (@(posedge clk) disable iff (rst)
        !$past(ok) |-> !px_valid); // R1
    AST_SEEK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEEK) && !vs_rise |=> (state == ST_SEEK)); // R3
    AST_SOF_WITH_PIXEL: assert property (@(posedge clk) disable iff (rst)
        px_sof |-> px_valid); // R4
    AST_EOL_WITH_PIXEL: assert property (@(posedge clk) disable iff (rst)
        px_eol |-> px_valid); // R5

endmodule

// File: rtl/ssc_geometry.sv
module ssc_geometry
    import ssc_pkg::*;
#(
    parameter int WIDTH_W  = 12,
    parameter int HEIGHT_W = 12,
    parameter int FCNT_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ok,
    input  logic                de,
    input  sync_edges_t         ev,
    input  logic                framing,
    output logic [WIDTH_W-1:0]  meas_width,
    output logic [HEIGHT_W-1:0] meas_height,
    output logic [HEIGHT_W-1:0] meas_lines,
    output logic [FCNT_W-1:0]   meas_fields,
    output logic                geom_stable
);

    logic [WIDTH_W-1:0]  pix_cnt;
    logic [WIDTH_W-1:0]  last_w;
    logic [HEIGHT_W-1:0] line_cnt;
    logic [HEIGHT_W-1:0] hs_cnt;
    logic                have_prev;
    logic                same_geom;

    assign same_geom = have_prev && (last_w == meas_width) && (line_cnt == meas_height);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_cnt     <= '0;
            last_w      <= '0;
            line_cnt    <= '0;
            hs_cnt      <= '0;
            have_prev   <= 1'b0;
            meas_width  <= '0;
            meas_height <= '0;
            meas_lines  <= '0;
            meas_fields <= '0;
            geom_stable <= 1'b0;
        end else if (ok) begin
            if (ev.vs_rise) begin
                if (framing) begin
                    meas_width  <= last_w;
                    meas_height <= line_cnt;
                    meas_lines  <= hs_cnt;
                    meas_fields <= meas_fields + FCNT_W'(1);
                    geom_stable <= same_geom;
                    have_prev   <= 1'b1;
                end
                line_cnt <= '0;
                last_w   <= '0;
                hs_cnt   <= HEIGHT_W'(ev.hs_rise);
                pix_cnt  <= WIDTH_W'(de);
            end else begin
                if (de) pix_cnt <= pix_cnt + WIDTH_W'(1);
                if (ev.de_fall) begin
                    last_w   <= pix_cnt;
                    pix_cnt  <= '0;
                    line_cnt <= line_cnt + HEIGHT_W'(1);
                end
                if (ev.hs_rise) hs_cnt <= hs_cnt + HEIGHT_W'(1);
            end
        end
    end

    AST_MEAS_ONLY_AT_VS: assert property (@(posedge clk) disable iff (rst)
        !$stable(meas_width) |-> $past(ok && ev.vs_rise)); // R7
    AST_FIELD_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(meas_fields) |-> (meas_fields == $past(meas_fields) + FCNT_W'(1))); // R9
    AST_STABLE_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(geom_stable) |-> (meas_width == $past(meas_width)) && (meas_height == $past(meas_height))); // R10
    AST_STABLE_DROP_AT_VS: assert property (@(posedge clk) disable iff (rst)
        $fell(geom_stable) |-> $past(ok && ev.vs_rise)); // R10

endmodule

// File: rtl/sepsync_capture.sv
module sepsync_capture
    import ssc_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int WIDTH_W  = 12,
    parameter int HEIGHT_W = 12,
    parameter int FCNT_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vin_ok,
    input  logic [DATA_W-1:0]   vin_data,
    input  logic                vin_de,
    input  logic                vin_hs,
    input  logic                vin_vs,
    input  logic                vin_fld,
    output logic [DATA_W-1:0]   px_data,
    output logic                px_valid,
    output logic                px_sof,
    output logic                px_eol,
    output logic                px_field,
    output logic [WIDTH_W-1:0]  meas_width,
    output logic [HEIGHT_W-1:0] meas_height,
    output logic [HEIGHT_W-1:0] meas_lines,
    output logic [FCNT_W-1:0]   meas_fields,
    output logic                geom_stable
);

    sync_edges_t ev;
    logic        framing;

    ssc_sampler u_sampler (
        .clk (clk),
        .rst (rst),
        .ok  (vin_ok),
        .de  (vin_de),
        .hs  (vin_hs),
        .vs  (vin_vs),
        .ev  (ev)
    );

    ssc_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ok       (vin_ok),
        .de       (vin_de),
        .fld      (vin_fld),
        .data     (vin_data),
        .vs_rise  (ev.vs_rise),
        .framing  (framing),
        .px_data  (px_data),
        .px_valid (px_valid),
        .px_sof   (px_sof),
        .px_eol   (px_eol),
        .px_field (px_field)
    );

    ssc_geometry #(
        .WIDTH_W  (WIDTH_W),
        .HEIGHT_W (HEIGHT_W),
        .FCNT_W   (FCNT_W)
    ) u_geom (
        .clk         (clk),
        .rst         (rst),
        .ok          (vin_ok),
        .de          (vin_de),
        .ev          (ev),
        .framing     (framing),
        .meas_width  (meas_width),
        .meas_height (meas_height),
        .meas_lines  (meas_lines),
        .meas_fields (meas_fields),
        .geom_stable (geom_stable)
    );

endmodule

// File: tb/sepsync_capture_test.sv
module sepsync_capture_test;

    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vin_ok = 1'b0;
    logic [DW-1:0] vin_data = '0;
    logic          vin_de = 1'b0;
    logic          vin_hs = 1'b0;
    logic          vin_vs = 1'b0;
    logic          vin_fld = 1'b0;
    logic [DW-1:0] px_data;
    logic          px_valid, px_sof, px_eol, px_field;
    logic [11:0]   meas_width, meas_height, meas_lines;
    logic [7:0]    meas_fields;
    logic          geom_stable;

    sepsync_capture uut (
        .clk(clk), .rst(rst), .vin_ok(vin_ok), .vin_data(vin_data),
        .vin_de(vin_de), .vin_hs(vin_hs), .vin_vs(vin_vs), .vin_fld(vin_fld),
        .px_data(px_data), .px_valid(px_valid), .px_sof(px_sof), .px_eol(px_eol),
        .px_field(px_field), .meas_width(meas_width), .meas_height(meas_height),
        .meas_lines(meas_lines), .meas_fields(meas_fields), .geom_stable(geom_stable)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [DW-1:0] d;
        logic          sof;
        logic          eol;
        logic          fld;
    } exp_px_t;

    exp_px_t sb[$];
    int checks = 0;
    int fails  = 0;
    int gap    = 0;
    bit done   = 1'b0;

    // requirement-level model state
    bit          m_pv, m_psof, m_pfld, m_framing, m_arm, m_fld, m_pvs;
    logic [DW-1:0] m_pd;
    bit          m_started, e_have, e_stab;
    int          lw, lh, e_w, e_h, e_l, e_fc;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: garbage on unqualified cycles, then one qualified sample
    task automatic q(input bit de, input bit hs, input bit vs, input bit f, input logic [DW-1:0] d);
        bit vs_rise;
        for (int i = 0; i < gap; i++) begin
            vin_ok   = 1'b0;
            vin_de   = ~vin_de;
            vin_hs   = ~vin_hs;
            vin_vs   = ~vin_vs;
            vin_fld  = ~vin_fld;
            vin_data = vin_data ^ 24'h5A5A5A;
            @(negedge clk);
        end
        vin_ok = 1'b1; vin_de = de; vin_hs = hs; vin_vs = vs; vin_fld = f; vin_data = d;
        if (m_pv) sb.push_back('{d: m_pd, sof: m_psof, eol: !de, fld: m_pfld});
        vs_rise = vs && !m_pvs;
        if (vs_rise) begin
            m_framing = 1'b1; m_fld = f; m_arm = 1'b1;
        end
        if (m_framing && de) begin
            m_pv = 1'b1; m_pd = d; m_psof = m_arm; m_pfld = m_fld; m_arm = 1'b0;
        end else begin
            m_pv = 1'b0;
        end
        m_pvs = vs;
        @(negedge clk);
        vin_ok = 1'b0;
    endtask

    task automatic check_status(input string tag);
        check("R7", {tag, " width"},  meas_width,  e_w);
        check("R7", {tag, " height"}, meas_height, e_h);
        check("R8", {tag, " lines"},  meas_lines,  e_l);
        check("R9", {tag, " fields"}, meas_fields, e_fc);
        check("R10", {tag, " stable"}, geom_stable, e_stab);
    endtask

    // One frame: sync line, blank line, h active lines of w pixels.
    // The field input carries f only on the opening sample (R6).
    task automatic frame(input string tag, input int w, input int h, input bit f, input int base);
        q(0, 1, 1, f, 0);
        if (m_started) begin
            e_stab = e_have && (lw == e_w) && (lh == e_h);
            e_w = lw; e_h = lh; e_l = lh + 2; e_fc++; e_have = 1'b1;
        end
        m_started = 1'b1; lw = w; lh = h;
        check_status(tag);
        q(0, 1, 1, !f, 0); q(0, 0, 1, !f, 0); q(0, 0, 0, !f, 0);
        q(0, 1, 0, !f, 0); q(0, 1, 0, !f, 0); q(0, 0, 0, !f, 0); q(0, 0, 0, !f, 0);
        for (int l = 0; l < h; l++) begin
            q(0, 1, 0, !f, 0); q(0, 1, 0, !f, 0); q(0, 0, 0, !f, 0);
            for (int p = 0; p < w; p++) q(1, 0, 0, !f, DW'(base + l * 16 + p));
            q(0, 0, 0, !f, 0); q(0, 0, 0, !f, 0);
        end
    endtask

    // Monitor / scoreboard
    logic ok_at_edge = 1'b0;
    always @(posedge clk) ok_at_edge <= vin_ok;

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (!ok_at_edge) check("R1", "valid after unqualified cycle", px_valid, 0);
            if (px_valid) begin
                if (sb.size() == 0) begin
                    check("R2", "unexpected pixel data", px_data, -1);
                end else begin
                    exp_px_t e;
                    e = sb.pop_front();
                    check("R2", "pixel data", px_data, e.d);
                    check("R4", "sof", px_sof, e.sof);
                    check("R5", "eol", px_eol, e.eol);
                    check("R6", "field", px_field, e.fld);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11", "px_valid after reset", px_valid, 0);
        check("R11", "width after reset", meas_width, 0);
        check("R11", "fields after reset", meas_fields, 0);
        check("R11", "stable after reset", geom_stable, 0);
        // R3: active samples before any vertical sync are dropped
        for (int p = 0; p < 3; p++) q(1, 0, 0, 0, DW'(24'hAA0000 + p));
        q(0, 0, 0, 0, 0);
        q(0, 0, 0, 0, 0);
        check("R3", "pixels queued before framing", sb.size(), 0);
        // R12: same geometry at several oversampling ratios
        gap = 0; frame("A", 4, 3, 0, 24'h100);
        gap = 2; frame("B", 4, 3, 1, 24'h200);
        gap = 1; frame("C", 4, 3, 0, 24'h300);
        gap = 0; frame("D", 1, 2, 1, 24'h400);
        gap = 3; frame("E", 1, 2, 0, 24'h500);
        gap = 0; frame("F", 5, 1, 1, 24'h600);
        frame("tail", 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check("R2", "pixels left unmatched", sb.size(), 0);
        // R11: reset clears status
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R11", "width after late reset", meas_width, 0);
        check("R11", "lines after late reset", meas_lines, 0);
        check("R11", "fields after late reset", meas_fields, 0);
        check("R11", "stable after late reset", geom_stable, 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule